// File: doc/BRIEF.md
# Ones-Fill and Rotate Shift Unit

This block is the shift stage of a 64-bit integer ALU. One datapath covers logical shifts and arithmetic shifts, plus two further operations: shifts that fill the vacated bit positions with ones, and rotates. A single direction bit chooses left or right for every kind of operation. A two-bit mode field, taken straight from instruction bits 30 and 29, chooses the kind.

The mode code that would mean an arithmetic left shift has no useful meaning of its own, so that code behaves as a plain logical left shift. A ones-fill left shift of a zero operand gives a mask of n low ones in a single operation.

The amount input is a full register value. Only its low log2(XLEN) bits are used; on the 64-bit build the sixth bit comes from instruction bit 25. The result is registered, so it appears one clock after the inputs are presented.

Top module: `shf_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `result_o` becomes all zeros.
- R2: `result_o` shows the operation on the inputs sampled at the previous rising clock edge. The inputs do not affect it before that edge.
- R3: Mode 2'b00 (logical) shifts by n with zero fill. `dir_right_i`=1 shifts toward bit 0; `dir_right_i`=0 shifts toward the MSB.
- R4: Mode 2'b10 with `dir_right_i`=1 shifts right and fills the vacated positions with operand bit XLEN-1.
- R5: Mode 2'b10 with `dir_right_i`=0 gives the same result as a logical left shift.
- R6: Mode 2'b01 shifts in the chosen direction and sets every vacated bit position to one.
- R7: Mode 2'b11 rotates by n in the chosen direction. Bits leaving one end re-enter at the other end.
- R8: The amount n is `amt_i[log2(XLEN)-1:0]`. Bits of `amt_i` above that field have no effect on the result.
- R9: An amount of zero returns the operand unchanged in every mode and in both directions.
- R10: Mode 2'b01 left applied to a zero operand yields exactly n ones, located in bits n-1 down to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| operand_i | input | XLEN | Value to shift |
| amt_i | input | XLEN | Shift amount register value; only the low log2(XLEN) bits are used |
| dir_right_i | input | 1 | 1 = right (toward bit 0), 0 = left |
| mode_i | input | 2 | {bit30, bit29}: 00 logical, 10 arithmetic, 01 ones-fill, 11 rotate |
| result_o | output | XLEN | Registered result |

## Verification
The bench builds the unit with its default XLEN of 64, which makes the amount field six bits wide. That width lets the bench sweep all 64 amounts in every mode and both directions, using operands with the sign bit set, the sign bit clear, and all zeros. The same setting brings the reused arithmetic-left code point, the zero-amount identity, the 63-position extremes and the mask-generator case within reach. Amounts with noise in the upper 58 bits show that those bits are discarded.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        MODE_LOGIC = 2'b00,
        MODE_ONES  = 2'b01,
        MODE_ARITH = 2'b10,
        MODE_ROT   = 2'b11
    } shf_mode_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'b00,
        FILL_ONE  = 2'b01,
        FILL_MSB  = 2'b10
    } shf_fill_e;

    typedef struct packed {
        logic      go_right;
        logic      wrap;
        shf_fill_e fill;
    } shf_ctl_t;

    function automatic shf_ctl_t decode_mode(input logic [1:0] mode, input logic right);
        shf_ctl_t c;
        c.go_right = right;
        c.wrap     = 1'b0;
        c.fill     = FILL_ZERO;
        unique case (shf_mode_e'(mode))
            MODE_LOGIC: c.fill = FILL_ZERO;
            MODE_ONES:  c.fill = FILL_ONE;
            MODE_ARITH: c.fill = right ? FILL_MSB : FILL_ZERO;
            MODE_ROT:   c.wrap = 1'b1;
            default:    c.fill = FILL_ZERO;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/shf_decode.sv
module shf_decode
    import shf_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       dir_right_i,
    output shf_ctl_t   ctl_o
);
    always_comb begin
        ctl_o = decode_mode(mode_i, dir_right_i);
    end
endmodule

// File: rtl/shf_mirror.sv
module shf_mirror #(
    parameter int XLEN = 64
) (
    input  logic            en_i,
    input  logic [XLEN-1:0] d_i,
    output logic [XLEN-1:0] q_o
);
    logic [XLEN-1:0] flipped;
    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        assign flipped[i] = d_i[XLEN-1-i];
    end
    assign q_o = en_i ? flipped : d_i;
endmodule

// File: rtl/shf_core.sv
module shf_core
    import shf_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int SHW = $clog2(XLEN)
) (
    input  shf_ctl_t        ctl_i,
    input  logic [SHW-1:0]  amt_i,
    input  logic [XLEN-1:0] operand_i,
    output logic [XLEN-1:0] result_o
);
    logic [XLEN-1:0] oriented;
    logic [XLEN-1:0] stg [SHW+1];
    logic            fill_bit;

    always_comb begin
        unique case (ctl_i.fill)
            FILL_ONE: fill_bit = 1'b1;
            FILL_MSB: fill_bit = operand_i[XLEN-1];
            default:  fill_bit = 1'b0;
        endcase
    end

    // Left operations are carried out as right operations on a mirrored word.
    shf_mirror #(.XLEN(XLEN)) u_pre (
        .en_i (~ctl_i.go_right),
        .d_i  (operand_i),
        .q_o  (oriented)
    );

    assign stg[0] = oriented;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        logic [STEP-1:0] incoming;
        assign incoming = ctl_i.wrap ? stg[k][STEP-1:0] : {STEP{fill_bit}};
        assign stg[k+1] = amt_i[k] ? {incoming, stg[k][XLEN-1:STEP]} : stg[k];
    end

    shf_mirror #(.XLEN(XLEN)) u_post (
        .en_i (~ctl_i.go_right),
        .d_i  (stg[SHW]),
        .q_o  (result_o)
    );
endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] operand_i,
    input  logic [XLEN-1:0] amt_i,
    input  logic            dir_right_i,
    input  logic [1:0]      mode_i,
    output logic [XLEN-1:0] result_o
);
    localparam int SHW = $clog2(XLEN);

    shf_ctl_t        ctl;
    logic [SHW-1:0]  amt_lo;
    logic [XLEN-1:0] comb_res;
    logic            unused_amt_hi;

    assign amt_lo        = amt_i[SHW-1:0];
    assign unused_amt_hi = ^amt_i[XLEN-1:SHW];

    shf_decode u_dec (
        .mode_i      (mode_i),
        .dir_right_i (dir_right_i),
        .ctl_o       (ctl)
    );

    shf_core #(.XLEN(XLEN)) u_core (
        .ctl_i     (ctl),
        .amt_i     (amt_lo),
        .operand_i (operand_i),
        .result_o  (comb_res)
    );

    always_ff @(posedge clk) begin
        if (rst) result_o <= '0;
        else     result_o <= comb_res;
    end

    // R1
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> result_o == '0);

    // R9
    a_r9_zero_amount: assert property (@(posedge clk) disable iff (rst)
        (amt_lo == '0) |=> result_o == $past(operand_i));

    // R7
    a_r7_rotate_keeps_ones: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b11) |=> $countones(result_o) == $countones($past(operand_i)));

    // R6
    a_r6_ones_right_msb: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b01 && dir_right_i && amt_lo != '0) |=> result_o[XLEN-1]);

    // R6
    a_r6_ones_left_lsb: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b01 && !dir_right_i && amt_lo != '0) |=> result_o[0]);

    // R4
    a_r4_sign_kept: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b10 && dir_right_i) |=> result_o[XLEN-1] == $past(operand_i[XLEN-1]));

    // R3
    a_r3_logic_right_msb_zero: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b00 && dir_right_i && amt_lo != '0) |=> !result_o[XLEN-1]);

    // R5
    a_r5_arith_left_lsb_zero: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b10 && !dir_right_i && amt_lo != '0) |=> !result_o[0]);

    // R10
    a_r10_mask_count: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b01 && !dir_right_i && operand_i == '0)
        |=> $countones(result_o) == int'($past(amt_lo)));
endmodule

// File: tb/sim_shf_unit.sv
module sim_shf_unit;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [XLEN-1:0] operand_i = '0;
    logic [XLEN-1:0] amt_i = '0;
    logic            dir_right_i = 1'b0;
    logic [1:0]      mode_i = 2'b00;
    logic [XLEN-1:0] result_o;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    shf_unit #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst(rst), .operand_i(operand_i), .amt_i(amt_i),
        .dir_right_i(dir_right_i), .mode_i(mode_i), .result_o(result_o)
    );

    function automatic logic [63:0] model(input logic [63:0] op, input int n,
                                          input bit right, input bit [1:0] mode);
        logic [63:0] r;
        bit fb;
        fb = (mode == 2'b01) ? 1'b1 : ((mode == 2'b10 && right) ? op[63] : 1'b0);
        for (int i = 0; i < 64; i++) begin
            int src;
            src = right ? i + n : i - n;
            if (src >= 0 && src < 64)  r[i] = op[src];
            else if (mode == 2'b11)    r[i] = op[(src + 64) % 64];
            else                       r[i] = fb;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_vec(input logic [63:0] op, input logic [63:0] amt,
                           input bit right, input bit [1:0] mode, input string tag);
        @(negedge clk);
        operand_i = op; amt_i = amt; dir_right_i = right; mode_i = mode;
        @(posedge clk); #1;
        check(tag, result_o, model(op, int'(amt[5:0]), right, mode));
    endtask

    function automatic string mode_tag(input bit [1:0] mode, input bit right);
        case (mode)
            2'b00:   return "R3";
            2'b10:   return right ? "R4" : "R5";
            2'b01:   return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        logic [63:0] ops [3];
        logic [63:0] prev;
        ops[0] = 64'h9E37_79B9_7F4A_7C15;
        ops[1] = 64'h1234_5678_0F0F_A5C3;
        ops[2] = 64'h0;

        // R1: reset clears the output
        @(negedge clk);
        operand_i = '1; amt_i = '0; mode_i = 2'b00;
        @(posedge clk); #1;
        check("R1", result_o, 64'h0);
        @(negedge clk); rst = 1'b0;

        // Exhaustive sweep over modes, directions and amounts
        for (int o = 0; o < 3; o++) begin
            for (int m = 0; m < 4; m++) begin
                for (int d = 0; d < 2; d++) begin
                    for (int n = 0; n < 64; n++) begin
                        string tag;
                        tag = mode_tag(2'(m), d[0]);
                        if (n == 0) tag = "R9";
                        else if (o == 2 && m == 1 && d == 0) tag = "R10";
                        run_vec(ops[o], 64'(n), d[0], 2'(m), tag);
                    end
                end
            end
        end

        // R10: explicit mask shape for n = 13
        run_vec(64'h0, 64'd13, 1'b0, 2'b01, "R10");
        check("R10", result_o, 64'h0000_0000_0000_1FFF);

        // R5: arithmetic left equals logical left
        run_vec(ops[0], 64'd7, 1'b0, 2'b10, "R5");
        check("R5", result_o, ops[0] << 7);

        // R8: upper amount bits ignored
        for (int k = 0; k < 8; k++) begin
            run_vec(ops[1], {58'h2AB_CDEF_1234_567 ^ 58'(k * 977), 6'(k * 9 + 1)},
                    k[0], 2'(k), "R8");
        end

        // R2: output unchanged before the clock edge, updates after
        run_vec(ops[0], 64'd4, 1'b1, 2'b00, "R2");
        prev = result_o;
        @(negedge clk);
        operand_i = ops[1]; amt_i = 64'd9; dir_right_i = 1'b0; mode_i = 2'b11;
        #1;
        check("R2", result_o, prev);
        @(posedge clk); #1;
        check("R2", result_o, model(ops[1], 9, 1'b0, 2'b11));

        // R1: reset in the middle of operation
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R1", result_o, 64'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule